// File: doc/BRIEF.md
# Receive Interrupt Coalescing Timer Unit

This block decides when a receive interrupt should be raised. It combines two countdown timers that count in units of a shared 1.024 µs tick, produced by a prescaler that divides the system clock. The quiet-gap timer is reloaded by every received packet. It fires only when the line has been silent for its programmed number of ticks, which groups a burst of packets into a single interrupt. The ceiling timer is armed by the first packet that follows an interrupt. Later packets do not reload it, so an interrupt still arrives within a bounded time when traffic never pauses.

When an interrupt fires, the block emits a one-cycle interrupt pulse, a matching one-cycle writeback-flush request and a two-bit cause code. Software-side writes reach the block as plain write strobes. The quiet-gap delay write carries a flush-now bit, which forces an immediate interrupt. No data stream passes through the block, so every pin is a plain control or status signal and no valid/ready handshake or back-pressure applies.

Top module: `rx_irq_coalesce`

## Requirements
- R1: Both countdowns change only on prescaler ticks. A tick occurs once every TICK_DIV clock cycles: on the TICK_DIV-th rising edge after reset is released, and on every TICK_DIV-th edge after that.
- R2: A packet strobe with a nonzero quiet-gap delay N loads the quiet-gap timer with N and starts it. The timer fires with cause 0 on the N-th tick after its last load, unless another packet reloads it first. A packet on the same edge as the expiring tick reloads the timer, and no interrupt fires.
- R3: With a quiet-gap delay of 0, every packet strobe produces its own interrupt with cause 0, and the timer stays stopped.
- R4: A quiet-gap delay write with the flush-now bit set produces an interrupt with cause 2 and stops the quiet-gap timer. The write also stores the new delay value.
- R5: A nonzero ceiling delay M is loaded by a packet only while the ceiling timer is idle. The ceiling timer fires with cause 1 on the M-th tick after that packet, even if packets keep arriving.
- R6: A ceiling delay of 0 disables the ceiling timer. Writing 0 while it is armed cancels the countdown, and no cause-1 interrupt follows.
- R7: A ceiling expiry suppresses any quiet-gap interrupt on that edge. It reloads the quiet-gap timer but leaves it stopped, so no quiet-gap interrupt follows until a later packet restarts it.
- R8: Every interrupt, whatever its cause, returns the ceiling timer to idle. It is re-armed only by a packet that arrives on a later edge.
- R9: Events that coincide on one edge give exactly one pulse. The cause is chosen in the order ceiling (1), then forced (2), then quiet-gap (0).
- R10: The interrupt pulse and the flush request are high together for one cycle per event, in the cycle right after the edge that sampled the event. The cause code is 0 for quiet-gap, 1 for ceiling and 2 for forced, and never 3.
- R11: After reset, both outputs are low, both delays are 0 and both timers are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_rcvd | input | 1 | One-cycle strobe per packet delivered to memory |
| gap_dly_we | input | 1 | Write strobe for the quiet-gap delay |
| gap_dly_wdata | input | DLY_W | New quiet-gap delay in ticks |
| gap_flush_now | input | 1 | With gap_dly_we, forces an immediate interrupt |
| cap_dly_we | input | 1 | Write strobe for the ceiling delay |
| cap_dly_wdata | input | DLY_W | New ceiling delay in ticks, 0 disables |
| wb_flush_req | output | 1 | One-cycle request to flush pending descriptor writebacks |
| irq_pulse | output | 1 | One-cycle receive-timer interrupt |
| irq_cause | output | 2 | Cause of the current pulse: 0 quiet-gap, 1 ceiling, 2 forced |

## Verification
The embedded assertions check the following on every cycle:
- ticks are never adjacent;
- a running quiet-gap count is never zero;
- an armed ceiling timer always holds a nonzero delay;
- a ceiling expiry stops the quiet-gap timer and idles the ceiling timer on the next edge;
- a pulse always carries the flush request and a legal cause;
- a ceiling expiry always surfaces as cause 1.

The exact edge on which each interrupt appears depends on the prescaler phase, on reloads and on cancellation. Only the bench's reference model can show this, by following packet bursts, forced flushes, disabling writes, coinciding expiries and a long random stretch.

// File: rtl/rx_irq_coalesce_pkg.sv
package rx_irq_coalesce_pkg;

  typedef enum logic [1:0] {
    CAUSE_GAP = 2'd0,
    CAUSE_CAP = 2'd1,
    CAUSE_FRC = 2'd2
  } irq_cause_e;

endpackage

// File: rtl/rxc_tick_gen.sv
module rxc_tick_gen #(
  parameter int TICK_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
  localparam bit POW2 = ((TICK_DIV & (TICK_DIV - 1)) == 0);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  generate
    if (POW2) begin : g_wrap
      // power-of-two divide: natural wrap of the counter
      always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_cmp
      always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/rxc_gap_timer.sv
module rxc_gap_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             pkt_i,
  input  logic             we_i,
  input  logic [DLY_W-1:0] wdata_i,
  input  logic             flush_i,
  input  logic             cap_fire_i,
  output logic             gap_fire_o,
  output logic             frc_fire_o
);
  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] cnt_q;
  logic             run_q;
  logic             imm_fire;
  logic             exp_fire;

  assign imm_fire   = pkt_i && (dly_q == '0);
  assign exp_fire   = run_q && tick_i && (cnt_q == DLY_W'(1)) && !pkt_i;
  assign gap_fire_o = imm_fire || exp_fire;
  assign frc_fire_o = we_i && flush_i;

  always_ff @(posedge clk) begin
    if (!rst_n) dly_q <= '0;
    else if (we_i) dly_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cap_fire_i) begin
      // ceiling expiry: reload but hold
      cnt_q <= dly_q;
      run_q <= 1'b0;
    end else if (frc_fire_o) begin
      run_q <= 1'b0;
    end else if (pkt_i) begin
      if (dly_q == '0) begin
        run_q <= 1'b0;
      end else begin
        cnt_q <= dly_q;
        run_q <= 1'b1;
      end
    end else if (run_q && tick_i) begin
      if (cnt_q == DLY_W'(1)) run_q <= 1'b0;
      else                    cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2
  run_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0));

  // R7
  cancel_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire_i |=> !run_q);

endmodule

// File: rtl/rxc_cap_timer.sv
module rxc_cap_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             pkt_i,
  input  logic             we_i,
  input  logic [DLY_W-1:0] wdata_i,
  input  logic             any_fire_i,
  output logic             cap_fire_o
);
  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] cnt_q;
  logic             arm_q;

  assign cap_fire_o = arm_q && tick_i && (cnt_q == DLY_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) dly_q <= '0;
    else if (we_i) dly_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (any_fire_i) begin
      arm_q <= 1'b0;
    end else if (we_i && (wdata_i == '0)) begin
      arm_q <= 1'b0;
    end else if (arm_q) begin
      if (tick_i) cnt_q <= cnt_q - 1'b1;
    end else if (pkt_i && (dly_q != '0)) begin
      cnt_q <= dly_q;
      arm_q <= 1'b1;
    end
  end

  // R6
  cap_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> (dly_q != '0));

  // R8
  idle_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_fire_i |=> !arm_q);

endmodule

// File: rtl/rx_irq_coalesce.sv
module rx_irq_coalesce
  import rx_irq_coalesce_pkg::*;
#(
  parameter int TICK_DIV = 128,
  parameter int DLY_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_rcvd,
  input  logic             gap_dly_we,
  input  logic [DLY_W-1:0] gap_dly_wdata,
  input  logic             gap_flush_now,
  input  logic             cap_dly_we,
  input  logic [DLY_W-1:0] cap_dly_wdata,
  output logic             wb_flush_req,
  output logic             irq_pulse,
  output logic [1:0]       irq_cause
);
  logic       tick;
  logic       gap_fire;
  logic       frc_fire;
  logic       cap_fire;
  logic       any_fire;
  irq_cause_e cause_d;

  rxc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  rxc_gap_timer #(.DLY_W(DLY_W)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .pkt_i      (pkt_rcvd),
    .we_i       (gap_dly_we),
    .wdata_i    (gap_dly_wdata),
    .flush_i    (gap_flush_now),
    .cap_fire_i (cap_fire),
    .gap_fire_o (gap_fire),
    .frc_fire_o (frc_fire)
  );

  rxc_cap_timer #(.DLY_W(DLY_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .pkt_i      (pkt_rcvd),
    .we_i       (cap_dly_we),
    .wdata_i    (cap_dly_wdata),
    .any_fire_i (any_fire),
    .cap_fire_o (cap_fire)
  );

  assign any_fire = cap_fire || frc_fire || gap_fire;

  always_comb begin
    if (cap_fire)      cause_d = CAUSE_CAP;
    else if (frc_fire) cause_d = CAUSE_FRC;
    else               cause_d = CAUSE_GAP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse    <= 1'b0;
      wb_flush_req <= 1'b0;
      irq_cause    <= 2'd0;
    end else begin
      irq_pulse    <= any_fire;
      wb_flush_req <= any_fire;
      irq_cause    <= any_fire ? cause_d : 2'd0;
    end
  end

  // R10
  flush_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> wb_flush_req);

  // R10
  cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (irq_cause != 2'd3));

  // R9
  cap_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (irq_pulse && irq_cause == 2'd1));

endmodule

// File: tb/rx_irq_coalesce_tb.sv
module rx_irq_coalesce_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int DW         = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pkt_rcvd = 1'b0;
  logic          gap_dly_we = 1'b0;
  logic [DW-1:0] gap_dly_wdata = '0;
  logic          gap_flush_now = 1'b0;
  logic          cap_dly_we = 1'b0;
  logic [DW-1:0] cap_dly_wdata = '0;
  logic          wb_flush_req;
  logic          irq_pulse;
  logic [1:0]    irq_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_irq_coalesce #(.TICK_DIV(TDIV), .DLY_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_rcvd(pkt_rcvd),
    .gap_dly_we(gap_dly_we), .gap_dly_wdata(gap_dly_wdata),
    .gap_flush_now(gap_flush_now), .cap_dly_we(cap_dly_we),
    .cap_dly_wdata(cap_dly_wdata), .wb_flush_req(wb_flush_req),
    .irq_pulse(irq_pulse), .irq_cause(irq_cause)
  );

  typedef struct {
    int        edge_n;
    logic [1:0] cause;
    string     tag;
  } exp_t;

  exp_t  sb_q[$];
  int    n_checks = 0;
  int    n_fail = 0;
  string scen_tag = "R11";
  int    cur_edge = 0;
  bit    done = 1'b0;

  // reference model state (cycle counts in edges since reset release)
  int unsigned m_edge = 0;
  int          m_gdly = 0, m_gcnt = 0, m_cdly = 0, m_ccnt = 0;
  bit          m_grun = 0, m_carm = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_edge = 0; m_gdly = 0; m_gcnt = 0; m_cdly = 0; m_ccnt = 0;
      m_grun = 0; m_carm = 0;
    end else begin
      bit tk, cf, ff, gf, any;
      exp_t it;
      tk = ((m_edge % TDIV) == TDIV - 1);
      cf = m_carm && tk && (m_ccnt == 1);
      ff = gap_dly_we && gap_flush_now;
      gf = (pkt_rcvd && m_gdly == 0) ||
           (m_grun && tk && m_gcnt == 1 && !pkt_rcvd);
      any = cf || ff || gf;
      if (any) begin
        it.edge_n = int'(m_edge);
        it.cause  = cf ? 2'd1 : (ff ? 2'd2 : 2'd0);
        it.tag    = cf ? "R5" : (ff ? "R4" : scen_tag);
        sb_q.push_back(it);
      end
      // quiet-gap timer
      if (cf) begin m_gcnt = m_gdly; m_grun = 0; end
      else if (ff) m_grun = 0;
      else if (pkt_rcvd) begin
        if (m_gdly == 0) m_grun = 0;
        else begin m_gcnt = m_gdly; m_grun = 1; end
      end else if (m_grun && tk) begin
        if (m_gcnt == 1) m_grun = 0; else m_gcnt--;
      end
      // ceiling timer
      if (any) m_carm = 0;
      else if (cap_dly_we && cap_dly_wdata == 0) m_carm = 0;
      else if (m_carm) begin if (tk) m_ccnt--; end
      else if (pkt_rcvd && m_cdly != 0) begin m_ccnt = m_cdly; m_carm = 1; end
      if (gap_dly_we) m_gdly = int'(gap_dly_wdata);
      if (cap_dly_we) m_cdly = int'(cap_dly_wdata);
      cur_edge = int'(m_edge);
      m_edge++;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wb_flush_req != irq_pulse) begin
        n_checks++; n_fail++;
        $display("FAIL R10: flush=%0b irq=%0b expected equal", wb_flush_req, irq_pulse);
      end
      if (irq_pulse) begin
        n_checks++;
        if (sb_q.size() == 0) begin
          n_fail++;
          $display("FAIL %s: unexpected pulse edge %0d cause %0d, expected none", scen_tag, cur_edge, irq_cause);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (e.edge_n != cur_edge || e.cause != irq_cause) begin
            n_fail++;
            $display("FAIL %s: pulse edge %0d cause %0d, expected edge %0d cause %0d",
                     e.tag, cur_edge, irq_cause, e.edge_n, e.cause);
          end
        end
      end else if (sb_q.size() > 0 && sb_q[0].edge_n <= cur_edge) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++; n_fail++;
        $display("FAIL %s: no pulse at edge %0d, expected cause %0d", e.tag, e.edge_n, e.cause);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pkt();
    @(negedge clk); pkt_rcvd = 1'b1;
    @(negedge clk); pkt_rcvd = 1'b0;
  endtask

  task automatic wr_gap(input int v, input bit fl);
    @(negedge clk); gap_dly_we = 1'b1; gap_dly_wdata = DW'(v); gap_flush_now = fl;
    @(negedge clk); gap_dly_we = 1'b0; gap_flush_now = 1'b0;
  endtask

  task automatic wr_cap(input int v);
    @(negedge clk); cap_dly_we = 1'b1; cap_dly_wdata = DW'(v);
    @(negedge clk); cap_dly_we = 1'b0;
  endtask

  task automatic finish_run();
    idle(10);
    n_checks++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10: %0d expected pulses never seen, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    // R11: outputs low in reset
    n_checks++;
    if (irq_pulse || wb_flush_req || irq_cause != 2'd0) begin
      n_fail++;
      $display("FAIL R11: irq=%0b flush=%0b cause=%0d, expected 0 0 0", irq_pulse, wb_flush_req, irq_cause);
    end
    rst_n = 1'b1;
    idle(5);
    // R11: delays are zero after reset, so a packet interrupts at once
    scen_tag = "R11"; pkt(); idle(20);
    // R3: zero gap delay, one pulse per packet, including back-to-back
    scen_tag = "R3";
    pkt(); idle(3); pkt(); idle(1);
    @(negedge clk); pkt_rcvd = 1'b1; @(negedge clk); @(negedge clk); pkt_rcvd = 1'b0;
    idle(20);
    // R1/R2: single tick delay, then longer delay with reloading burst
    scen_tag = "R1"; wr_gap(1, 0); pkt(); idle(12); pkt(); idle(3); pkt(); idle(12);
    scen_tag = "R2"; wr_gap(3, 0); pkt(); idle(30);
    for (int i = 0; i < 6; i++) begin pkt(); idle(5); end
    idle(30);
    // R4: forced flush while running and while idle
    scen_tag = "R4"; wr_gap(10, 0); pkt(); idle(8); wr_gap(10, 1); idle(60);
    wr_gap(2, 1); idle(20);
    // R5/R7/R8: continuous traffic with a ceiling
    scen_tag = "R7"; wr_gap(5, 0); wr_cap(6);
    for (int i = 0; i < 14; i++) begin pkt(); idle(6); end
    idle(60);
    // R6: ceiling disabled, and cancelled while armed
    scen_tag = "R6"; wr_cap(0);
    for (int i = 0; i < 10; i++) begin pkt(); idle(6); end
    idle(40);
    wr_cap(8); pkt(); idle(6); wr_cap(0); idle(60);
    // R9: both timers expire on one tick
    scen_tag = "R9"; wr_gap(4, 0); wr_cap(4); idle(7); pkt(); idle(40);
    // R9: forced flush alongside a packet with zero gap delay
    wr_cap(0); wr_gap(0, 0);
    @(negedge clk); pkt_rcvd = 1'b1; gap_dly_we = 1'b1; gap_flush_now = 1'b1; gap_dly_wdata = '0;
    @(negedge clk); pkt_rcvd = 1'b0; gap_dly_we = 1'b0; gap_flush_now = 1'b0;
    idle(10);
    // R8/R10: long random stretch checked against the model
    scen_tag = "R8";
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      pkt_rcvd      = ($urandom_range(0, 99) < 30);
      gap_dly_we    = ($urandom_range(0, 99) < 2);
      gap_dly_wdata = DW'($urandom_range(0, 6));
      gap_flush_now = gap_dly_we && ($urandom_range(0, 3) == 0);
      cap_dly_we    = ($urandom_range(0, 99) < 2);
      cap_dly_wdata = DW'($urandom_range(0, 8));
    end
    @(negedge clk);
    pkt_rcvd = 1'b0; gap_dly_we = 1'b0; gap_flush_now = 1'b0; cap_dly_we = 1'b0;
    idle(100);
    finish_run();
  end

endmodule